// File: doc/BRIEF.md
# MDIO Management Frame Master

This block is the sequencer behind a station-management port. Software places a control word in a command register. The word carries the start code, the opcode, the PHY address and the register address. Setting the go bit in that same word makes the block emit one Clause 22 management frame. The block derives MDC from the system clock through a run-time half-period setting. It shifts the frame out on MDIO with the most significant bit first, and it controls the MDIO output enable so that an external tri-state pad can be attached.

Writes and reads both pass through one 32-bit data register. Software loads outgoing write data into the lower half before it sets go. For a read, the block releases MDIO at the turnaround field, samples the sixteen bits that the PHY returns, and stores them in the upper half of the data register when the frame ends. The go bit reads back as a busy flag and drops on its own when the frame is over, so software polls it to learn that the transfer has finished.

Top module: `mdio_frame_master`

## Requirements
- R1: In reset, `mdc` and `mdioOe` are low, and `cmdStatus` and `dataReg` are all zeros.
- R2: A write frame is 64 MDC cycles of MDIO bits in this order: 32 ones, start code, opcode 01, PHY address, register address, turnaround 10, then `dataReg[15:0]`. Every field goes MSB first and the output enable stays high for all 64 bits.
- R3: A command write with bit 20 set starts a frame when the block is idle. `cmdStatus[20]` reads 1 while the frame runs and returns to 0 by itself after the 64th MDC cycle. The command word layout is: register address in bits 4:0, PHY address in bits 9:5, opcode in bits 11:10, start code in bits 13:12, go in bit 20.
- R4: For a read (opcode 10), the first 46 bits are sent as in R2. From the first turnaround bit to the end of the frame `mdioOe` is low, and `dataReg[15:0]` has no effect on the frame.
- R5: During a read, MDIO is sampled on the 16 rising MDC edges of the data field. At the end of the frame the sampled word, MSB first, appears in `dataReg[31:16]`, and `dataReg[15:0]` is left unchanged.
- R6: One MDC period is 2 × `mdcHalf` system clocks. `mdioOut` changes only when MDC falls or when a frame starts, so it is stable at every rising MDC edge.
- R7: A command write made while a frame is running is ignored. `cmdStatus` keeps its value and the running frame is unchanged.
- R8: When a frame ends, `mdioOe` is low and `mdc` stays low until the next frame.
- R9: `dataWrite` loads `dataWord` into `dataReg[15:0]` at any time, including while a frame is running.
- R10: A command write with bit 20 clear stores the word so that it reads back in `cmdStatus` and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdWrite | input | 1 | Write strobe for the command register |
| cmdWord | input | 32 | Command word: fields and go bit |
| cmdStatus | output | 32 | Command readback; bit 20 is the busy/go flag |
| dataWrite | input | 1 | Write strobe for the low half of the data register |
| dataWord | input | 16 | Outgoing write data |
| dataReg | output | 32 | Read data in 31:16, write data in 15:0 |
| mdcHalf | input | DIV_W | MDC half period in system clocks (0 is treated as 1) |
| mdc | output | 1 | Management clock |
| mdioOut | output | 1 | Serial data toward the pad |
| mdioOe | output | 1 | Pad output enable |
| mdioIn | input | 1 | Serial data from the pad |

## Verification
Two events can land on the same system clock edge. One is the end of a read, which loads the captured word into the upper half of the data register and drops busy. The other is software writing the lower half. The bench provokes this by writing a new value to the lower half on every cycle while a read runs, so one of those writes falls on the completion edge. Afterwards it requires the upper half to hold the PHY's word and the lower half to hold the last value written. A command write that overlaps a running frame is judged the same way: the status is compared with a snapshot taken before the write, and the frame bits are compared with the original command.

// File: rtl/mdio_frame_pkg.sv
package mdio_frame_pkg;
  localparam int PRE_BITS   = 32;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int HDR_BITS   = 2 + 2 + ADDR_W + ADDR_W;
  localparam int TA_POS     = PRE_BITS + HDR_BITS;
  localparam int DATA_POS   = TA_POS + 2;
  localparam int FRAME_BITS = DATA_POS + DATA_W;
  localparam int CNT_W      = $clog2(FRAME_BITS);
  localparam int CMD_W      = 32;
  localparam int GO_BIT     = 20;
  localparam int REG_LSB    = 0;
  localparam int PHY_LSB    = 5;
  localparam int OP_LSB     = 10;
  localparam int ST_LSB     = 12;

  localparam logic [1:0] OP_READ  = 2'b10;
  localparam logic [1:0] TA_WRITE = 2'b10;

  typedef struct packed {
    logic load;    // latch a new frame image
    logic shift;   // falling MDC: advance to next bit
    logic sample;  // rising MDC in read data field
    logic finish;  // end of read: commit captured word
  } seqStrobe_t;
endpackage

// File: rtl/mdio_seq_ctrl.sv
module mdio_seq_ctrl
  import mdio_frame_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdWrite,
  input  logic [CMD_W-1:0]  cmdWord,
  input  logic [DIV_W-1:0]  mdcHalf,
  output logic [CMD_W-1:0]  cmdStatus,
  output logic              busy,
  output logic              mdc,
  output logic              mdioOe,
  output seqStrobe_t        stb
);
  localparam logic [CNT_W-1:0] TA_IDX   = CNT_W'(TA_POS);
  localparam logic [CNT_W-1:0] DATA_IDX = CNT_W'(DATA_POS);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(FRAME_BITS - 1);

  logic [CMD_W-1:0] cmdReg;
  logic [DIV_W-1:0] divCnt;
  logic [DIV_W-1:0] halfEff;
  logic [CNT_W-1:0] bitCnt;
  logic [CNT_W-1:0] nextCnt;
  logic             mdcReg, oeReg, isRead;
  logic             startNow, tick, riseNow, fallNow, lastBit, doneNow, shiftNow;

  assign halfEff  = (mdcHalf == '0) ? DIV_W'(1) : mdcHalf;
  assign startNow = cmdWrite && cmdWord[GO_BIT] && !busy;
  assign tick     = busy && (divCnt == halfEff - DIV_W'(1));
  assign riseNow  = tick && !mdcReg;
  assign fallNow  = tick && mdcReg;
  assign lastBit  = (bitCnt == LAST_IDX);
  assign doneNow  = fallNow && lastBit;
  assign shiftNow = fallNow && !lastBit;
  assign nextCnt  = bitCnt + CNT_W'(1);

  always_comb begin
    stb.load   = startNow;
    stb.shift  = shiftNow;
    stb.sample = riseNow && isRead && (bitCnt >= DATA_IDX);
    stb.finish = doneNow && isRead;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdReg <= '0;
      busy   <= 1'b0;
      divCnt <= '0;
      bitCnt <= '0;
      mdcReg <= 1'b0;
      oeReg  <= 1'b0;
      isRead <= 1'b0;
    end else if (startNow) begin
      cmdReg <= cmdWord;
      busy   <= 1'b1;
      isRead <= (cmdWord[OP_LSB +: 2] == OP_READ);
      divCnt <= '0;
      bitCnt <= '0;
      mdcReg <= 1'b0;
      oeReg  <= 1'b1;
    end else if (cmdWrite && !busy) begin
      cmdReg <= cmdWord;
    end else if (busy) begin
      if (tick) begin
        divCnt <= '0;
        mdcReg <= !mdcReg;
      end else begin
        divCnt <= divCnt + DIV_W'(1);
      end
      if (shiftNow) begin
        bitCnt <= nextCnt;
        if (isRead && nextCnt >= TA_IDX) oeReg <= 1'b0;
      end
      if (doneNow) begin
        busy  <= 1'b0;
        oeReg <= 1'b0;
      end
    end
  end

  always_comb begin
    cmdStatus         = cmdReg;
    cmdStatus[GO_BIT] = busy;
  end

  assign mdc    = mdcReg;
  assign mdioOe = oeReg;

  assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdcReg && !oeReg));

  assert_go_clear_R3: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> ($past(bitCnt) == LAST_IDX && $past(mdcReg)));

  assert_read_release_R4: assert property (@(posedge clk) disable iff (!rstN)
    (busy && isRead && bitCnt >= TA_IDX) |-> !oeReg);

  assert_busy_hold_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && cmdWrite && !doneNow) |=> (busy && $stable(cmdReg)));
endmodule

// File: rtl/mdio_shift_path.sv
module mdio_shift_path
  import mdio_frame_pkg::*;
(
  input  logic                clk,
  input  logic                rstN,
  input  seqStrobe_t          stb,
  input  logic [1:0]          startCode,
  input  logic [1:0]          opCode,
  input  logic [ADDR_W-1:0]   phyAddr,
  input  logic [ADDR_W-1:0]   regAddr,
  input  logic                dataWrite,
  input  logic [DATA_W-1:0]   dataWord,
  input  logic                mdioIn,
  output logic                mdioOut,
  output logic [2*DATA_W-1:0] dataReg
);
  logic [FRAME_BITS-1:0] shiftReg;
  logic [FRAME_BITS-1:0] frameImg;
  logic [DATA_W-1:0]     capReg;
  logic                  readOp;

  assign readOp = (opCode == OP_READ);

  always_comb begin
    frameImg = {{PRE_BITS{1'b1}}, startCode, opCode, phyAddr, regAddr,
                readOp ? 2'b11 : TA_WRITE,
                readOp ? {DATA_W{1'b1}} : dataReg[DATA_W-1:0]};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      shiftReg <= '0;
      capReg   <= '0;
      dataReg  <= '0;
    end else begin
      if (stb.load)       shiftReg <= frameImg;
      else if (stb.shift) shiftReg <= {shiftReg[FRAME_BITS-2:0], 1'b1};
      if (stb.sample)     capReg   <= {capReg[DATA_W-2:0], mdioIn};
      if (dataWrite)      dataReg[DATA_W-1:0] <= dataWord;
      if (stb.finish)     dataReg[2*DATA_W-1:DATA_W] <= capReg;
    end
  end

  assign mdioOut = shiftReg[FRAME_BITS-1];

  assert_high_half_R5: assert property (@(posedge clk) disable iff (!rstN)
    !$past(stb.finish) |-> $stable(dataReg[2*DATA_W-1:DATA_W]));
endmodule

// File: rtl/mdio_frame_master.sv
module mdio_frame_master
  import mdio_frame_pkg::*;
#(
  parameter int DIV_W = 8
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                cmdWrite,
  input  logic [CMD_W-1:0]    cmdWord,
  output logic [CMD_W-1:0]    cmdStatus,
  input  logic                dataWrite,
  input  logic [DATA_W-1:0]   dataWord,
  output logic [2*DATA_W-1:0] dataReg,
  input  logic [DIV_W-1:0]    mdcHalf,
  output logic                mdc,
  output logic                mdioOut,
  output logic                mdioOe,
  input  logic                mdioIn
);
  seqStrobe_t stb;
  logic       busyW;

  mdio_seq_ctrl #(.DIV_W(DIV_W)) uCtrl (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdWord(cmdWord),
    .mdcHalf(mdcHalf), .cmdStatus(cmdStatus), .busy(busyW),
    .mdc(mdc), .mdioOe(mdioOe), .stb(stb)
  );

  mdio_shift_path uPath (
    .clk(clk), .rstN(rstN), .stb(stb),
    .startCode(cmdWord[ST_LSB +: 2]), .opCode(cmdWord[OP_LSB +: 2]),
    .phyAddr(cmdWord[PHY_LSB +: ADDR_W]), .regAddr(cmdWord[REG_LSB +: ADDR_W]),
    .dataWrite(dataWrite), .dataWord(dataWord), .mdioIn(mdioIn),
    .mdioOut(mdioOut), .dataReg(dataReg)
  );

  assert_mdio_edge_R6: assert property (@(posedge clk) disable iff (!rstN)
    (!$fell(mdc) && !$rose(busyW)) |-> $stable(mdioOut));
endmodule

// File: tb/sim_mdio_frame_master.sv
module sim_mdio_frame_master;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        cmdWrite = 1'b0;
  logic [31:0] cmdWord = '0;
  logic [31:0] cmdStatus;
  logic        dataWrite = 1'b0;
  logic [15:0] dataWord = '0;
  logic [31:0] dataReg;
  logic [7:0]  mdcHalf = 8'd2;
  logic        mdc, mdioOut, mdioOe;
  logic        mdioIn = 1'b1;

  always #5 clk = ~clk;

  mdio_frame_master u0 (
    .clk(clk), .rstN(rstN), .cmdWrite(cmdWrite), .cmdWord(cmdWord),
    .cmdStatus(cmdStatus), .dataWrite(dataWrite), .dataWord(dataWord),
    .dataReg(dataReg), .mdcHalf(mdcHalf), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .mdioIn(mdioIn)
  );

  int checks = 0;
  int fails = 0;
  int cyc = 0;

  // PHY model: samples on rising MDC, answers on falling MDC
  int          posCount = 0;
  logic        capBit [64];
  logic        capOe  [64];
  time         riseT  [2];
  logic [15:0] phyWord = '0;

  always @(posedge mdc) begin
    if (posCount < 64) begin
      capBit[posCount] = mdioOut;
      capOe[posCount]  = mdioOe;
    end
    if (posCount < 2) riseT[posCount] = $time;
    posCount++;
  end

  always @(negedge mdc) begin
    if (posCount >= 48 && posCount < 64) mdioIn = phyWord[4'(63 - posCount)];
    else mdioIn = 1'b1;
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      checks++; fails++;
      $display("FAIL watchdog: actual %0d cycles expected < 150000", cyc);
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic logic [31:0] mkCmd(input logic go, input logic [1:0] op,
                                        input logic [4:0] phy, input logic [4:0] rg);
    mkCmd = '0;
    mkCmd[20] = go; mkCmd[13:12] = 2'b01; mkCmd[11:10] = op;
    mkCmd[9:5] = phy; mkCmd[4:0] = rg;
  endfunction

  function automatic logic [63:0] expFrame(input logic rd, input logic [4:0] phy,
                                           input logic [4:0] rg, input logic [15:0] wd);
    expFrame = {32'hFFFF_FFFF, 2'b01, rd ? 2'b10 : 2'b01, phy, rg,
                rd ? 2'b11 : 2'b10, rd ? 16'hFFFF : wd};
  endfunction

  function automatic logic [63:0] gotFrame();
    for (int k = 0; k < 64; k++) gotFrame[63-k] = capBit[k];
  endfunction

  function automatic logic [63:0] gotOe();
    for (int k = 0; k < 64; k++) gotOe[63-k] = capOe[k];
  endfunction

  task automatic issue(input logic [31:0] w);
    @(negedge clk); cmdWrite = 1'b1; cmdWord = w;
    @(negedge clk); cmdWrite = 1'b0;
  endtask

  task automatic loadData(input logic [15:0] w);
    @(negedge clk); dataWrite = 1'b1; dataWord = w;
    @(negedge clk); dataWrite = 1'b0;
  endtask

  task automatic waitIdle();
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (!cmdStatus[20]) break;
    end
  endtask

  typedef struct packed {
    logic        rd;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic [15:0] rv;
    logic [7:0]  half;
  } vec_t;

  localparam logic [50:0] VECS [4] = '{
    {1'b0, 5'h01, 5'h02, 16'hA5C3, 16'h0000, 8'd2},
    {1'b1, 5'h1F, 5'h00, 16'h1234, 16'h3C96, 8'd2},
    {1'b0, 5'h10, 5'h1F, 16'h8001, 16'h0000, 8'd3},
    {1'b1, 5'h00, 5'h15, 16'h7E7E, 16'h0001, 8'd1}
  };

  initial begin
    vec_t v;
    logic [63:0] ef, gf, eo;
    logic [31:0] snap;
    logic [15:0] lastW;

    repeat (3) @(negedge clk);
    check(mdc == 1'b0 && mdioOe == 1'b0, "R1", "reset mdc/oe", {62'b0, mdc, mdioOe}, 64'h0);
    check(cmdStatus == 32'h0, "R1", "reset status", 64'(cmdStatus), 64'h0);
    check(dataReg == 32'h0, "R1", "reset data", 64'(dataReg), 64'h0);
    rstN = 1'b1;
    @(negedge clk);

    // Table-driven frames
    for (int i = 0; i < 4; i++) begin
      v = VECS[i];
      mdcHalf = v.half;
      phyWord = v.rv;
      loadData(v.wd);
      check(dataReg[15:0] == v.wd, "R9", "low half load", 64'(dataReg[15:0]), 64'(v.wd));
      posCount = 0;
      issue(mkCmd(1'b1, v.rd ? 2'b10 : 2'b01, v.phy, v.rg));
      check(cmdStatus[20] == 1'b1, "R3", "busy while running", 64'(cmdStatus[20]), 64'h1);
      waitIdle();
      check(cmdStatus[20] == 1'b0, "R3", "go self-clears", 64'(cmdStatus[20]), 64'h0);
      check(posCount == 64, "R2", "MDC cycle count", 64'(posCount), 64'd64);
      ef = expFrame(v.rd, v.phy, v.rg, v.wd);
      gf = gotFrame();
      if (v.rd) begin
        check(gf[63:18] == ef[63:18], "R4", "read header bits", gf, ef);
        eo = {{46{1'b1}}, 18'b0};
        check(gotOe() == eo, "R4", "read output enable", gotOe(), eo);
        check(dataReg[31:16] == v.rv, "R5", "read word", 64'(dataReg[31:16]), 64'(v.rv));
        check(dataReg[15:0] == v.wd, "R5", "low half kept", 64'(dataReg[15:0]), 64'(v.wd));
      end else begin
        check(gf == ef, "R2", "write frame bits", gf, ef);
        check(gotOe() == {64{1'b1}}, "R2", "write output enable", gotOe(), {64{1'b1}});
      end
      check(riseT[1] - riseT[0] == 64'(20 * v.half), "R6", "MDC period",
            64'(riseT[1] - riseT[0]), 64'(20 * v.half));
      check(mdc == 1'b0 && mdioOe == 1'b0, "R8", "idle after frame",
            {62'b0, mdc, mdioOe}, 64'h0);
      repeat (10) @(negedge clk);
      check(mdc == 1'b0 && mdioOe == 1'b0, "R8", "stays idle", {62'b0, mdc, mdioOe}, 64'h0);
    end

    // R10: command without go is stored only
    posCount = 0;
    snap = mkCmd(1'b0, 2'b10, 5'h0A, 5'h05) | 32'h000C_0000;
    issue(snap);
    repeat (60) @(negedge clk);
    check(cmdStatus == snap, "R10", "stored fields", 64'(cmdStatus), 64'(snap));
    check(posCount == 0, "R10", "no MDC activity", 64'(posCount), 64'h0);

    // R7: command during a running frame is ignored
    mdcHalf = 8'd1;
    loadData(16'h5A0F);
    posCount = 0;
    issue(mkCmd(1'b1, 2'b01, 5'h03, 5'h11));
    repeat (30) @(negedge clk);
    snap = cmdStatus;
    issue(mkCmd(1'b1, 2'b10, 5'h1C, 5'h07));
    check(cmdStatus == snap, "R7", "status unchanged", 64'(cmdStatus), 64'(snap));
    waitIdle();
    ef = expFrame(1'b0, 5'h03, 5'h11, 16'h5A0F);
    check(gotFrame() == ef, "R7", "frame unaffected", gotFrame(), ef);
    check(posCount == 64, "R7", "single frame only", 64'(posCount), 64'd64);

    // Read completion coinciding with low-half writes (R5, R9)
    mdcHalf = 8'd2;
    phyWord = 16'hC3A5;
    posCount = 0;
    lastW = dataReg[15:0];
    issue(mkCmd(1'b1, 2'b10, 5'h04, 5'h09));
    for (int k = 0; k < 20000; k++) begin
      @(negedge clk);
      if (!cmdStatus[20]) break;
      dataWrite = 1'b1;
      dataWord = 16'(k * 7 + 3);
      lastW = dataWord;
    end
    dataWrite = 1'b0;
    @(negedge clk);
    check(dataReg[31:16] == 16'hC3A5, "R5", "overlap read word", 64'(dataReg[31:16]), 64'hC3A5);
    check(dataReg[15:0] == lastW, "R9", "overlap low write", 64'(dataReg[15:0]), 64'(lastW));

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule